// File: doc/BRIEF.md
# I2S Capture Buffer with Fill-Level Interrupt

This block takes 12-bit PCM audio words from a slow I2S analog-to-digital converter and parks them in a small dual-clock FIFO. A much faster host bus can then collect them without stalling on the serial peripheral. The bit-clock side shifts in serial data and writes each finished word into the FIFO with no help from the host. The host side either polls with a single-cycle read strobe, or it sleeps until a level interrupt reports that enough samples are waiting.

Each FIFO entry holds a channel tag and the sample. The host sees the entry zero-extended to 16 bits, one cycle after its read strobe. A host-writable threshold sets the fill level that raises the interrupt. If a word completes while the FIFO is full, that word is discarded and a sticky overflow flag is raised in the host domain. The flag stays set until the host clears it. When the capture path is unused, a capture-enable input freezes the deserializer so its registers stop toggling.

Top module: `i2s_capture_fifo`

## Requirements
- R1: Serial data is sampled on the rising bit-clock edge, MSB first. The first bit of a word is the one sampled on the edge after the edge at which a change of `ws` is seen. `ws` low tags a word as left (tag 0) and `ws` high tags it as right (tag 1).
- R2: A read returns `rd_data` one host clock after `rd_stb`. Bits 11:0 carry the sample, bit 12 carries the channel tag, and bits 15:13 are zero.
- R3: Words leave in the order they were captured, and up to 16 words can be held.
- R4: A read while the FIFO is empty returns zero and does not advance the read position, so the next stored word is still the one returned next.
- R5: `irq` is high exactly while the host-side fill count is at or above the threshold. The threshold is loaded from `thr_wdata` when `thr_we` is high and resets to 8.
- R6: A word that completes while the FIFO is full is dropped, and `ovf` then rises and stays high until `ovf_clr` is pulsed.
- R7: While `cap_en` is low, the deserializer holds its state and no word enters the FIFO.
- R8: After reset, `rd_data`, `irq` and `ovf` are all zero.
- R9: Bits that arrive after the 12th bit of a word, before the next `ws` change, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Audio bit clock |
| bclk_rst_n | input | 1 | Active-low async reset, bit-clock domain |
| cap_en | input | 1 | Capture enable; low freezes the deserializer |
| ws | input | 1 | Word select (0 left, 1 right) |
| sd | input | 1 | Serial audio data |
| hclk | input | 1 | Host bus clock |
| hrst_n | input | 1 | Active-low async reset, host domain |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_data | output | 16 | Read word: tag at bit 12, sample at bits 11:0 |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 5 | New interrupt threshold, 0 to 16 |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq | output | 1 | Level interrupt: fill count at or above threshold |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong bit count or a missed `ws` change shows up at the first read after the frame: bits are shifted, or the tag bit is wrong. A read pointer that advances on an empty read shows up as a skipped word on the next read. Corrupt Gray-pointer crossing appears as a wrong `irq` level a few host cycles after a frame, or as lost and reordered words when the FIFO fills. A wrong full condition shows up either as `ovf` staying low after the seventeenth word, or as a stored word being overwritten in the sixteen-word readback.

// File: rtl/i2s_capture_fifo.sv
module i2s_capture_fifo #(
  parameter int DW      = 12,
  parameter int AW      = 4,
  parameter int BW      = 16,
  parameter int THR_RST = 8
) (
  input  logic          bclk,
  input  logic          bclk_rst_n,
  input  logic          cap_en,
  input  logic          ws,
  input  logic          sd,
  input  logic          hclk,
  input  logic          hrst_n,
  input  logic          rd_stb,
  output logic [BW-1:0] rd_data,
  input  logic          thr_we,
  input  logic [AW:0]   thr_wdata,
  input  logic          ovf_clr,
  output logic          irq,
  output logic          ovf
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = DW + 1;
  localparam int CW    = $clog2(DW);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [EW-1:0] mem [DEPTH];

  // bit-clock domain
  logic          ws_q, busy, chan, drop_tgl;
  logic [CW-1:0] cnt;
  logic [DW-2:0] shreg;
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic          push, full;
  logic [AW:0]   wbin_nx;

  assign push    = cap_en && busy && (ws == ws_q) && (cnt == CW'(DW - 1));
  assign full    = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge bclk or negedge bclk_rst_n)
    if (!bclk_rst_n) begin
      ws_q <= 1'b1; busy <= 1'b0; chan <= 1'b0; cnt <= '0; shreg <= '0;
      wbin <= '0; wgray <= '0; drop_tgl <= 1'b0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (cap_en) begin
        ws_q <= ws;
        if (ws != ws_q) begin
          busy <= 1'b1; cnt <= '0; chan <= ws;
        end else if (busy) begin
          shreg <= {shreg[DW-3:0], sd};
          cnt   <= cnt + 1'b1;
          if (push) begin
            busy <= 1'b0;
            if (full) drop_tgl <= ~drop_tgl;
            else begin
              wbin  <= wbin_nx;
              wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
          end
        end
      end
    end

  always_ff @(posedge bclk)
    if (push && !full) mem[wbin[AW-1:0]] <= {chan, shreg, sd};

  // host domain
  logic [AW:0] rbin, rgray, wq1, wq2, cnt_h, thr;
  logic [2:0]  dsync;
  logic        empty;

  assign empty = (rgray == wq2);
  assign cnt_h = g2b(wq2) - rbin;
  assign irq   = (cnt_h >= thr);

  always_ff @(posedge hclk or negedge hrst_n)
    if (!hrst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0; dsync <= '0;
      rd_data <= '0; thr <= (AW+1)'(THR_RST); ovf <= 1'b0;
    end else begin
      wq1   <= wgray;
      wq2   <= wq1;
      dsync <= {dsync[1:0], drop_tgl};
      if (thr_we) thr <= thr_wdata;
      if (ovf_clr) ovf <= 1'b0;
      else if (dsync[2] != dsync[1]) ovf <= 1'b1;
      if (rd_stb) begin
        if (empty) rd_data <= '0;
        else begin
          rd_data <= BW'(mem[rbin[AW-1:0]]);
          rbin    <= rbin + 1'b1;
          rgray   <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        end
      end
    end

  // R4
  empty_read_zero_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    (rd_stb && empty) |=> (rd_data == '0));
  // R3
  fill_bound_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    cnt_h <= (AW+1)'(DEPTH));
  // R6
  ovf_sticky_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R5
  thr_zero_irq_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    (thr_we && thr_wdata == '0) |=> irq);
  // R7
  hold_when_off_chk: assert property (@(posedge bclk) disable iff (!bclk_rst_n)
    !cap_en |=> $stable(wbin));
endmodule

// File: tb/sim_i2s_capture_fifo.sv
`timescale 1ns/1ps
module sim_i2s_capture_fifo;
  logic bclk = 0, hclk = 0, rst_n = 0;
  logic cap_en = 1, ws = 1, sd = 0;
  logic rd_stb = 0, thr_we = 0, ovf_clr = 0;
  logic [4:0]  thr_wdata = 0;
  logic [15:0] rd_data;
  logic irq, ovf;
  int checks = 0, errors = 0, model_cnt = 0;
  logic [12:0] exp_q[$];

  always #4  hclk = ~hclk;
  always #40 bclk = ~bclk;

  i2s_capture_fifo u0 (
    .bclk(bclk), .bclk_rst_n(rst_n), .cap_en(cap_en), .ws(ws), .sd(sd),
    .hclk(hclk), .hrst_n(rst_n), .rd_stb(rd_stb), .rd_data(rd_data),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .ovf_clr(ovf_clr),
    .irq(irq), .ovf(ovf));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [11:0] l, input logic [11:0] r);
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 16; k++) begin
        @(negedge bclk);
        if (k == 0) begin ws = ch[0]; sd = 0; end
        else if (k <= 12) sd = (ch == 0) ? l[12-k] : r[12-k];
        else sd = 1'b1; // R9 junk bits
      end
      if (cap_en && model_cnt < 16) begin
        exp_q.push_back({ch[0], (ch == 0) ? l : r});
        model_cnt++;
      end
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge hclk);
  endtask

  task automatic host_read(input string req);
    logic [15:0] e;
    @(negedge hclk); rd_stb = 1;
    @(negedge hclk); rd_stb = 0;
    if (exp_q.size() == 0) e = 16'h0;
    else begin e = {3'b000, exp_q.pop_front()}; model_cnt--; end
    chk(req, rd_data, e);
  endtask

  task automatic set_thr(input logic [4:0] v);
    @(negedge hclk); thr_we = 1; thr_wdata = v;
    @(negedge hclk); thr_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge hclk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge hclk);
    // R8 reset state
    chk("R8 rd_data", rd_data, 16'h0);
    chk("R8 irq", {15'b0, irq}, 16'h0);
    chk("R8 ovf", {15'b0, ovf}, 16'h0);
    @(negedge bclk); rst_n = 1;
    settle();

    // R1 R2 R9 basic capture, tags and bit order
    send_frame(12'hA5C, 12'h3F1);
    settle();
    host_read("R1 left word");
    host_read("R2 right word");

    // R4 empty read
    host_read("R4 empty read");
    send_frame(12'h001, 12'h800);
    settle();
    host_read("R4 no pointer move");
    host_read("R1 msb only");

    // R5 threshold
    set_thr(5'd2);
    chk("R5 irq low empty", {15'b0, irq}, 16'h0);
    send_frame(12'h123, 12'hFED);
    settle();
    chk("R5 irq at threshold", {15'b0, irq}, 16'h1);
    host_read("R3 order a");
    chk("R5 irq below threshold", {15'b0, irq}, 16'h0);
    host_read("R3 order b");

    // R7 capture disabled
    set_thr(5'd1);
    @(negedge bclk); cap_en = 0;
    send_frame(12'h777, 12'h555);
    settle();
    chk("R7 irq no capture", {15'b0, irq}, 16'h0);
    host_read("R7 read empty");
    @(negedge bclk); cap_en = 1;

    // R6 R3 fill, overflow, readback
    set_thr(5'd16);
    for (int f = 0; f < 7; f++) send_frame(12'(f * 37 + 5), 12'(12'hF00 - f * 91));
    settle();
    chk("R5 irq at 14 of 16", {15'b0, irq}, 16'h0);
    send_frame(12'h0F0, 12'h00F);
    settle();
    chk("R5 irq full", {15'b0, irq}, 16'h1);
    chk("R6 no ovf yet", {15'b0, ovf}, 16'h0);
    send_frame(12'hBAD, 12'hCAB);
    settle();
    chk("R6 ovf set", {15'b0, ovf}, 16'h1);
    for (int i = 0; i < 16; i++) host_read("R3 full readback");
    host_read("R6 dropped word absent");
    chk("R5 irq empty", {15'b0, irq}, 16'h0);
    chk("R6 ovf sticky", {15'b0, ovf}, 16'h1);
    @(negedge hclk); ovf_clr = 1;
    @(negedge hclk); ovf_clr = 0;
    chk("R6 ovf cleared", {15'b0, ovf}, 16'h0);
    send_frame(12'h246, 12'h9AC);
    settle();
    chk("R6 ovf stays clear", {15'b0, ovf}, 16'h0);
    host_read("R2 after overflow l");
    host_read("R2 after overflow r");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule